// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes (or 9-bit words) over a single serial line using asynchronous NRZ framing. The host writes a word into a holding register. When the internal shift register is free, the word moves into it in one clock. The host can then write the next word while the current frame is still on the line. The line idles high. A frame is a low start bit, then the data bits least significant bit first, then a high stop bit.

Bit timing comes from an internal baud generator. An 8-bit divisor gives one prescaler tick every `divisor+1` system clocks. Each bit lasts 16 ticks in high-speed mode and 64 ticks otherwise. Two indications tell the host what the block is doing:
- A buffer-empty flag, which can also drive an interrupt.
- A shifter-empty status, which raises no interrupt and has to be polled.

Disabling the port or the transmitter aborts any frame in progress and flushes the holding register.

The FSM has four states:
- ST_IDLE: the shifter is empty and the line is high.
- ST_START: the start bit is being sent.
- ST_DATA: the data bits are being shifted out.
- ST_STOP: the stop bit is being sent.

Its transitions are:
- LOAD: ST_IDLE to ST_START, when the block is enabled and the holding register is full. This is the one-cycle hand-off.
- BIT_END: ST_START to ST_DATA, at the end of the start bit.
- LAST_DATA: ST_DATA to ST_STOP, at the end of data bit 7, or of bit 8 in 9-bit mode.
- FRAME_END: ST_STOP to ST_IDLE, at the end of the stop bit.
- ABORT: any state to ST_IDLE, when `port_en` or `tx_en` is low.

Top module: `serial_tx_dbuf`

## Requirements
- R1: A frame on `txd` is one low start bit, then the data bits least significant bit first, then one high stop bit. With `nine_bit`=0 the frame carries 8 data bits.
- R2: With `nine_bit`=1 a ninth data bit follows bit 7. Its value is `ninth_in` as sampled on the clock edge of the write, not its value at send time.
- R3: Every bit of a frame lasts exactly (`divisor`+1)×16 clocks when `hi_speed`=1, and (`divisor`+1)×64 clocks when `hi_speed`=0.
- R4: The shifter loads from the holding register only while it is empty and the holding register is full. The transfer takes one clock. The start bit begins on the edge after the write edge when the shifter was idle. Back-to-back frames are separated by exactly one idle high clock.
- R5: `buf_empty` is 1 exactly when the block is enabled and the holding register is empty. Enabling the block sets it. A write clears it on the write edge. A transfer sets it on the transfer edge.
- R6: `int_en` has no effect on `buf_empty`.
- R7: `shift_empty` is 1 while no frame is in the shifter. It is 0 from the transfer edge until the end of the stop bit. While it is 1, `txd` is high.
- R8: `irq` equals `buf_empty` AND `int_en`.
- R9: When `port_en` or `tx_en` is 0, any frame is aborted on the next edge and `txd` stays high. The holding register is emptied and writes are ignored.
- R10: After reset `txd`=1, `shift_empty`=1, `buf_empty`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| hi_speed | input | 1 | 1 selects 16 prescaler ticks per bit, 0 selects 64 |
| divisor | input | 8 | Baud divisor; prescaler tick every divisor+1 clocks |
| int_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Data byte to write |
| ninth_in | input | 1 | Ninth data bit, latched with the write |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt request |

## Verification
The main function is tried with four frame patterns, and each one separates a different class of error:
- Alternating and asymmetric bytes (0xA5, 0x3C) expose bit-order and off-by-one shift errors.
- A 9-bit word whose `ninth_in` changes after the write separates "latched at write" from "read at send".
- Two baud settings (fast ×16 with divisors 0 and 1, slow ×64 with divisor 2) separate the prescale choice from the divisor arithmetic.
- Back-to-back writes, with the second landing while the first frame is on the line, show the single idle cycle between frames and the flag sequencing.

A reference model with a queue of expected line levels compares `txd`, `buf_empty`, `shift_empty` and `irq` on every clock. This catches any timing slip of a single cycle.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    localparam int TICKS_FAST = 16;
    localparam int TICKS_SLOW = 64;

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
    parameter int DIV_W = 8,
    parameter int FAST  = 16,
    parameter int SLOW  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    input  logic             hi_speed,
    output logic             bit_done
);
    localparam int SUB_W = $clog2(SLOW);

    logic [DIV_W-1:0] pre_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic [SUB_W-1:0] sub_last;
    logic             tick;

    // ticks per bit minus one, picked by the speed select
    assign sub_last = hi_speed ? SUB_W'(FAST - 1) : SUB_W'(SLOW - 1);
    assign tick     = run && (pre_cnt == divisor);
    assign bit_done = tick && (sub_cnt == sub_last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            sub_cnt <= (sub_cnt == sub_last) ? '0 : sub_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (!active) begin
            full <= 1'b0;          // flush; writes ignored while disabled
        end else if (wr_en) begin
            full <= 1'b1;          // a write beside a take keeps the new word
            word <= wr_word;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_tx_fsm.sv
module serial_tx_fsm
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            hold_full,
    input  logic [DATA_W:0] hold_word,
    input  logic            nine_bit,
    input  logic            bit_done,
    output logic            take,
    output logic            run,
    output logic            txd,
    output logic            idle
);
    localparam int WORD_W = DATA_W + 1;
    localparam int IDX_W  = $clog2(WORD_W + 1);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              nine_q;
    logic              load;

    assign load     = (state_q == ST_IDLE) && active && hold_full;
    assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load)     state_d = ST_START;   // LOAD
            ST_START: if (bit_done) state_d = ST_DATA;    // BIT_END
            ST_DATA:  if (bit_done && idx_q == last_idx)
                                    state_d = ST_STOP;    // LAST_DATA
            ST_STOP:  if (bit_done) state_d = ST_IDLE;    // FRAME_END
            default:                state_d = ST_IDLE;
        endcase
        if (!active) state_d = ST_IDLE;                   // ABORT
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shifter and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            nine_q  <= 1'b0;
        end else if (load) begin
            shift_q <= hold_word;
            idx_q   <= '0;
            nine_q  <= nine_bit;
        end else if (state_q == ST_DATA && bit_done) begin
            shift_q <= shift_q >> 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        take = load;
        run  = (state_q != ST_IDLE);
        idle = (state_q == ST_IDLE);
        unique case (state_q)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shift_q[0];
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              hi_speed,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              int_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth_in,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq
);
    localparam int WORD_W = DATA_W + 1;

    logic              active;
    logic              hold_full;
    logic [WORD_W-1:0] hold_word;
    logic              take;
    logic              run;
    logic              bit_done;
    logic              fsm_idle;

    assign active = port_en && tx_en;

    serial_tx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .wr_en   (wr_en),
        .wr_word ({ninth_in, wr_data}),
        .take    (take),
        .full    (hold_full),
        .word    (hold_word)
    );

    serial_tx_baud #(.DIV_W(DIV_W), .FAST(TICKS_FAST), .SLOW(TICKS_SLOW)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .divisor  (divisor),
        .hi_speed (hi_speed),
        .bit_done (bit_done)
    );

    serial_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .nine_bit  (nine_bit),
        .bit_done  (bit_done),
        .take      (take),
        .run       (run),
        .txd       (txd),
        .idle      (fsm_idle)
    );

    assign buf_empty   = active && !hold_full;
    assign shift_empty = fsm_idle;
    assign irq         = buf_empty && int_en;

endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic tx_en,
    input logic int_en,
    input logic wr_en,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq
);
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);                                            // R7

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);                                    // R1

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);                                               // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && tx_en) |=> shift_empty);                            // R9

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && tx_en && wr_en) |=> (!buf_empty || !(port_en && tx_en))); // R5

    AST_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(buf_empty) && port_en && tx_en && $past(port_en && tx_en)) |-> $past(wr_en)); // R5

    AST_HANDOFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(buf_empty) && $past(port_en && tx_en)) |-> !shift_empty); // R4

endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .tx_en       (tx_en),
    .int_en      (int_en),
    .wr_en       (wr_en),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .irq         (irq)
);

// File: tb/serial_tx_dbuf_tb.sv
`timescale 1ns/1ps
module serial_tx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, tx_en = 1'b0, nine_bit = 1'b0, hi_speed = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       int_en = 1'b0, wr_en = 1'b0, ninth_in = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, buf_empty, shift_empty, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    serial_tx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
        .nine_bit(nine_bit), .hi_speed(hi_speed), .divisor(divisor),
        .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data), .ninth_in(ninth_in),
        .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
    );

    // ---------------- reference model: queue of expected line levels
    bit       lineq[$];
    int       bit_cnt = 0;
    bit       m_full  = 1'b0;
    bit [8:0] m_word  = '0;

    function automatic int bit_len();
        return (int'(divisor) + 1) * (hi_speed ? 16 : 64);
    endfunction

    always @(posedge clk) begin
        bit took;
        took = 1'b0;
        if (!rst_n || !(port_en && tx_en)) begin
            lineq.delete();
            bit_cnt = 0;
            m_full  = 1'b0;
        end else begin
            if (lineq.size() != 0) begin
                bit_cnt++;
                if (bit_cnt == bit_len()) begin
                    void'(lineq.pop_front());
                    bit_cnt = 0;
                end
            end else if (m_full) begin
                lineq.push_back(1'b0);
                for (int i = 0; i < (nine_bit ? 9 : 8); i++) lineq.push_back(m_word[i]);
                lineq.push_back(1'b1);
                bit_cnt = 0;
                took = 1'b1;
            end
            if (wr_en) begin
                m_full = 1'b1;
                m_word = {ninth_in, wr_data};
            end else if (took) begin
                m_full = 1'b0;
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_buf;
            e_buf = port_en && tx_en && !m_full;
            check("R1 txd vs model", txd, (lineq.size() != 0) ? lineq[0] : 1'b1);
            check("R7 shift_empty vs model", shift_empty, lineq.size() == 0);
            check("R5 buf_empty vs model", buf_empty, e_buf);
            check("R8 irq vs model", irq, e_buf && int_en);
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R4: got hung run expected completion");
        finish_sim();
    end

    task automatic write_word(logic [7:0] d, logic n9);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d; ninth_in = n9;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (!(shift_empty && buf_empty));
    endtask

    // sample one frame at bit centres; the start bit is detected first
    task automatic rx_frame(int nbits, int len, output logic [8:0] val);
        val = '0;
        do @(negedge clk); while (txd !== 1'b0);
        repeat (len / 2) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            repeat (len) @(negedge clk);
            val[k] = txd;
        end
        repeat (len) @(negedge clk);
        check("R1 stop bit high", txd, 1'b1);
    endtask

    task automatic start_len(int exp_len, string tag);
        int n;
        n = 0;
        do @(negedge clk); while (txd !== 1'b0);
        while (txd === 1'b0) begin
            n++;
            @(negedge clk);
        end
        checks++;
        if (n != exp_len) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, n, exp_len);
        end
    endtask

    task automatic check_word(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        logic [8:0] w;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        check("R10 txd", txd, 1'b1);
        check("R10 shift_empty", shift_empty, 1'b1);
        check("R10 buf_empty", buf_empty, 1'b0);
        check("R10 irq", irq, 1'b0);

        // R5 enabling sets the flag; R6 int_en low leaves it alone
        #1; port_en = 1'b1; tx_en = 1'b1; hi_speed = 1'b1; divisor = 8'd0;
        @(negedge clk);
        check("R5 enable sets buf_empty", buf_empty, 1'b1);
        check("R6 buf_empty with int_en=0", buf_empty, 1'b1);
        check("R8 irq masked", irq, 1'b0);
        #1 int_en = 1'b1;
        @(negedge clk);
        check("R8 irq follows flag", irq, 1'b1);
        check("R6 buf_empty with int_en=1", buf_empty, 1'b1);

        // R4 hand-off timing, R3 fast bit length (divisor 0, x16)
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = 8'hA5; ninth_in = 1'b0;
        @(negedge clk);
        check("R5 write clears buf_empty", buf_empty, 1'b0);
        check("R4 line idle on write edge", txd, 1'b1);
        #1 wr_en = 1'b0;
        @(negedge clk);
        check("R4 start bit after transfer", txd, 1'b0);
        check("R4 transfer sets buf_empty", buf_empty, 1'b1);
        check("R7 shifter busy after transfer", shift_empty, 1'b0);
        wait_quiet();

        write_word(8'h81, 1'b0);
        start_len(16, "R3 fast div0 bit length");
        wait_quiet();

        // R1 8-bit frame content
        write_word(8'h3C, 1'b0);
        rx_frame(8, 16, w);
        check_word("R1 8-bit frame", w, 9'h03C);
        wait_quiet();

        // R2 ninth bit latched at write
        #1 nine_bit = 1'b1;
        write_word(8'h5A, 1'b1);
        #1 ninth_in = 1'b0;
        rx_frame(9, 16, w);
        check_word("R2 9-bit frame", w, 9'h15A);
        wait_quiet();
        #1 nine_bit = 1'b0;

        // R3 slow mode: divisor 2, x64 -> 192 clocks per bit
        #1; hi_speed = 1'b0; divisor = 8'd2;
        write_word(8'h81, 1'b0);
        start_len(192, "R3 slow div2 bit length");
        wait_quiet();

        // R4/R5 back-to-back, divisor 1 x16
        #1; hi_speed = 1'b1; divisor = 8'd1;
        write_word(8'h11, 1'b0);
        do @(negedge clk); while (buf_empty !== 1'b1);
        write_word(8'h22, 1'b0);
        check("R5 second word pending", buf_empty, 1'b0);
        check("R7 first frame on line", shift_empty, 1'b0);
        wait_quiet();

        // R9 abort and ignored writes
        write_word(8'hF0, 1'b0);
        repeat (40) @(negedge clk);
        #1 tx_en = 1'b0;
        @(negedge clk);
        check("R9 abort line high", txd, 1'b1);
        check("R9 abort shifter empty", shift_empty, 1'b1);
        check("R9 flag low while disabled", buf_empty, 1'b0);
        write_word(8'h00, 1'b0);
        #1 tx_en = 1'b1;
        @(negedge clk);
        check("R9 write ignored: buf_empty", buf_empty, 1'b1);
        repeat (5) @(negedge clk);
        check("R9 write ignored: no frame", shift_empty, 1'b1);
        check("R9 write ignored: line high", txd, 1'b1);

        // port enable drop also aborts
        write_word(8'h0F, 1'b0);
        repeat (10) @(negedge clk);
        #1 port_en = 1'b0;
        @(negedge clk);
        check("R9 port disable aborts", shift_empty, 1'b1);
        check("R9 port disable line high", txd, 1'b1);

        repeat (4) @(negedge clk);
        finish_sim();
    end

endmodule